// File: doc/BRIEF.md
# DMA Channel Request Mask Unit

This block keeps one mask bit for each channel of an eight-channel DMA controller. The controller is built as two groups of four channels. The lower group (channels 0 to 3) reaches the arbiter through channel 4 of the upper group, which acts as its cascade input. The host can change the mask bits in three ways:

- load all four bits of a group in one write;
- change one selected bit of a group;
- force a whole group to the masked state with a master-clear pulse.

Two other events also set mask bits. A channel that reaches terminal count sets its own bit, unless it is programmed for auto-initialise. Reset sets every bit.

Raw request lines first pass through a synchroniser. They are then gated by the registered mask bits before they reach the arbiter. A read port returns the mask state of the selected group in the low nibble, with the upper nibble at zero. Host bus decoding, priority arbitration and the address and count registers are outside this block. Only their terminal-count and auto-initialise indications come in.

Top module: `dma_req_mask_unit`

## Requirements
- R1: While reset is active and after its release, all eight mask bits are 1. A read of either group returns 0x0F, and no masked request output is active.
- R2: A write-all to a group loads data bits 3:0 into that group's mask bits at the next clock edge. Bit 0 maps to the group's lowest channel. Data bits 7:4 have no effect. The other group is not changed.
- R3: The read port returns the mask bits of the group named by `rd_grp` in bits 3:0, combinationally. Bits 7:4 are always 0.
- R4: A single-bit write carries a 3-bit value. Bits 1:0 select the channel within the group, and bit 2 is the new mask value. Only the selected bit changes, at the next clock edge.
- R5: If a single-bit write and a write-all target the same group in the same cycle, the single-bit value wins for the selected bit. The write-all data sets the other three bits.
- R6: A terminal-count pulse on a channel sets its mask bit at the next edge. If that channel's auto-initialise input is high, the pulse has no effect on the mask.
- R7: If a terminal-count set and a host write that clears the same bit occur in the same cycle, the bit ends at 1.
- R8: A master-clear pulse for a group forces all four of its bits to 1 at the next edge. This overrides host writes and terminal count, and it leaves the other group unchanged.
- R9: Each output `dreq_out[i]` is the synchronised request ANDed with the inverse of mask bit i. A raw request that rises just after a clock edge appears at the output after the second following edge, and never before it.
- R10: While mask bit 4 is 1, `dreq_out[3:0]` are all 0, whatever the lower group's mask bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; sets all mask bits |
| wr_all_en | input | 1 | Write-all strobe |
| wr_all_grp | input | 1 | Group targeted by write-all (0 = channels 0-3) |
| wr_all_data | input | 8 | Write-all data; bits 3:0 are used |
| wr_one_en | input | 1 | Single-bit write strobe |
| wr_one_grp | input | 1 | Group targeted by single-bit write |
| wr_one_data | input | 3 | Bits 1:0 select the channel, bit 2 is the mask value |
| mclr | input | 2 | Master clear, one bit per group |
| tc_pulse | input | 8 | Terminal count, one bit per channel |
| autoinit | input | 8 | Auto-initialise mode, one bit per channel |
| rd_grp | input | 1 | Group selected for readback |
| rd_data | output | 8 | Mask status of the selected group |
| dreq_raw | input | 8 | Asynchronous request lines |
| dreq_out | output | 8 | Masked, synchronised requests to the arbiter |

## Verification
A wrong mask bit shows up in two places in the same cycle as the register update. It changes the group's nibble on the read port, and it lets a request through, or blocks it, on `dreq_out`. The bench therefore reads the mask back after every operation. A fault in the cascade gating appears only when mask bit 4 is set while lower-group requests are high, so that case is driven on purpose. Synchroniser depth faults appear as one-edge early or late request edges, which are sampled between edges.

// File: rtl/dma_mask_pkg.sv
package dma_mask_pkg;
  localparam int GRP_CH     = 4;
  localparam int GRP_CNT    = 2;
  localparam int NCH        = GRP_CH * GRP_CNT;
  localparam int SEL_W      = $clog2(GRP_CH);
  localparam int GRP_W      = $clog2(GRP_CNT);
  localparam int CASCADE_CH = GRP_CH;
  localparam int REG_W      = 8;

  typedef logic [GRP_CH-1:0] grp_mask_t;

  // next mask value of one group; later steps override earlier ones
  function automatic grp_mask_t mask_next(
    input grp_mask_t        cur,
    input logic             clr,
    input logic             ld_all,
    input grp_mask_t        all_bits,
    input logic             ld_one,
    input logic [SEL_W-1:0] sel,
    input logic             val,
    input grp_mask_t        tc_hit
  );
    grp_mask_t n;
    grp_mask_t oh;
    n  = cur;
    oh = grp_mask_t'(1) << sel;
    if (ld_all) n = all_bits;
    if (ld_one) n = val ? (n | oh) : (n & ~oh);
    n = n | tc_hit;
    if (clr) n = '1;
    return n;
  endfunction

  // gate requests: own mask, plus cascade mask for the lower group
  function automatic logic [NCH-1:0] gate_req(
    input logic [NCH-1:0] req,
    input logic [NCH-1:0] mask
  );
    logic [NCH-1:0] g;
    g = req & ~mask;
    if (mask[CASCADE_CH]) g[GRP_CH-1:0] = '0;
    return g;
  endfunction
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dma_mask_group.sv
module dma_mask_group
  import dma_mask_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ld_all,
  input  grp_mask_t        all_bits,
  input  logic             ld_one,
  input  logic [SEL_W-1:0] sel,
  input  logic             val,
  input  grp_mask_t        tc_hit,
  output grp_mask_t        mask
);
  grp_mask_t mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_next(mask_q, clr, ld_all, all_bits, ld_one, sel, val, tc_hit);
  end

  assign mask = mask_q;
endmodule

// File: rtl/dma_req_gate.sv
module dma_req_gate
  import dma_mask_pkg::*;
(
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] mask,
  output logic [NCH-1:0] gated
);
  assign gated = gate_req(req, mask);
endmodule

// File: rtl/dma_req_mask_unit.sv
module dma_req_mask_unit
  import dma_mask_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_all_en,
  input  logic             wr_all_grp,
  input  logic [REG_W-1:0] wr_all_data,
  input  logic             wr_one_en,
  input  logic             wr_one_grp,
  input  logic [2:0]       wr_one_data,
  input  logic [1:0]       mclr,
  input  logic [7:0]       tc_pulse,
  input  logic [7:0]       autoinit,
  input  logic             rd_grp,
  output logic [REG_W-1:0] rd_data,
  input  logic [7:0]       dreq_raw,
  output logic [7:0]       dreq_out
);
  // named internal events, used by the checker
  logic [NCH-1:0] mask_vec;
  logic [NCH-1:0] req_sync;
  logic [NCH-1:0] tc_set;

  assign tc_set = tc_pulse & ~autoinit;

  dma_req_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(dreq_raw), .q(req_sync)
  );

  generate
    for (genvar g = 0; g < GRP_CNT; g++) begin : g_grp
      logic hit_all, hit_one;
      grp_mask_t m;
      assign hit_all = wr_all_en && (wr_all_grp == GRP_W'(g));
      assign hit_one = wr_one_en && (wr_one_grp == GRP_W'(g));
      dma_mask_group u_grp (
        .clk(clk), .rst_n(rst_n), .clr(mclr[g]),
        .ld_all(hit_all), .all_bits(wr_all_data[GRP_CH-1:0]),
        .ld_one(hit_one), .sel(wr_one_data[SEL_W-1:0]), .val(wr_one_data[SEL_W]),
        .tc_hit(tc_set[g*GRP_CH +: GRP_CH]), .mask(m)
      );
      assign mask_vec[g*GRP_CH +: GRP_CH] = m;
    end
  endgenerate

  dma_req_gate u_gate (.req(req_sync), .mask(mask_vec), .gated(dreq_out));

  assign rd_data = {{(REG_W-GRP_CH){1'b0}}, mask_vec[GRP_CH*rd_grp +: GRP_CH]};
endmodule

// File: rtl/dma_mask_chk.sv
module dma_mask_chk
  import dma_mask_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_all_en,
  input logic             wr_all_grp,
  input logic [REG_W-1:0] wr_all_data,
  input logic             wr_one_en,
  input logic             wr_one_grp,
  input logic [1:0]       mclr,
  input logic [NCH-1:0]   tc_set,
  input logic [NCH-1:0]   mask_vec,
  input logic [REG_W-1:0] rd_data,
  input logic [NCH-1:0]   dreq_out
);
  // R3
  rd_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:4] == 4'h0);

  // R6
  tc_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_set != '0) |=> ((mask_vec & $past(tc_set)) == $past(tc_set)));

  // R8
  mclr_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclr[0] |=> (mask_vec[3:0] == 4'hF));

  // R8
  mclr_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclr[1] |=> (mask_vec[7:4] == 4'hF));

  // R2
  wr_all_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_all_en && !wr_all_grp && !mclr[0] && !(wr_one_en && !wr_one_grp) && tc_set[3:0] == '0)
    |=> (mask_vec[3:0] == $past(wr_all_data[3:0])));

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq_out & mask_vec) == '0);

  // R10
  cascade_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_vec[4] |-> (dreq_out[3:0] == 4'h0));
endmodule

bind dma_req_mask_unit dma_mask_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_all_en(wr_all_en), .wr_all_grp(wr_all_grp),
  .wr_all_data(wr_all_data), .wr_one_en(wr_one_en), .wr_one_grp(wr_one_grp),
  .mclr(mclr), .tc_set(tc_set), .mask_vec(mask_vec), .rd_data(rd_data),
  .dreq_out(dreq_out)
);

// File: tb/dma_req_mask_unit_tb.sv
module dma_req_mask_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_all_en = 0, wr_all_grp = 0;
  logic [7:0] wr_all_data = 0;
  logic       wr_one_en = 0, wr_one_grp = 0;
  logic [2:0] wr_one_data = 0;
  logic [1:0] mclr = 0;
  logic [7:0] tc_pulse = 0, autoinit = 0;
  logic       rd_grp = 0;
  logic [7:0] rd_data;
  logic [7:0] dreq_raw = 0;
  logic [7:0] dreq_out;

  int checks = 0, errors = 0;
  logic [7:0] mdl;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_req_mask_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_all_en(wr_all_en), .wr_all_grp(wr_all_grp),
    .wr_all_data(wr_all_data), .wr_one_en(wr_one_en), .wr_one_grp(wr_one_grp),
    .wr_one_data(wr_one_data), .mclr(mclr), .tc_pulse(tc_pulse), .autoinit(autoinit),
    .rd_grp(rd_grp), .rd_data(rd_data), .dreq_raw(dreq_raw), .dreq_out(dreq_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic chk_mask(input string req);
    rd_grp = 0; #1; chk(req, rd_data, {4'h0, mdl[3:0]});
    rd_grp = 1; #1; chk(req, rd_data, {4'h0, mdl[7:4]});
  endtask

  // all driven strobes are applied for one edge, then cleared
  task automatic step;
    @(posedge clk); @(negedge clk);
    wr_all_en = 0; wr_one_en = 0; mclr = 0; tc_pulse = 0;
  endtask

  task automatic t_reset;
    mdl = 8'hFF;
    chk_mask("R1");
    chk("R1", dreq_out, 8'h00);
  endtask

  task automatic t_write_all;
    wr_all_en = 1; wr_all_grp = 0; wr_all_data = 8'hA5; step;
    mdl[3:0] = 4'h5; chk_mask("R2");
    wr_all_en = 1; wr_all_grp = 1; wr_all_data = 8'hF0; step;
    mdl[7:4] = 4'h0; chk_mask("R2");
  endtask

  task automatic t_single;
    wr_one_en = 1; wr_one_grp = 1; wr_one_data = 3'b110; step;
    mdl[6] = 1; chk_mask("R4");
    wr_one_en = 1; wr_one_grp = 0; wr_one_data = 3'b000; step;
    mdl[0] = 0; chk_mask("R4");
  endtask

  task automatic t_single_vs_all;
    wr_all_en = 1; wr_all_grp = 0; wr_all_data = 8'h00;
    wr_one_en = 1; wr_one_grp = 0; wr_one_data = 3'b111; step;
    mdl[3:0] = 4'h8; chk_mask("R5");
  endtask

  task automatic t_tc;
    autoinit = 8'h02;
    tc_pulse = 8'h03; step;
    mdl[0] = 1; chk_mask("R6");
    tc_pulse = 8'h02; step;
    chk_mask("R6");
    autoinit = 0;
  endtask

  task automatic t_tc_vs_write;
    wr_all_en = 1; wr_all_grp = 1; wr_all_data = 8'h00; tc_pulse = 8'h20; step;
    mdl[7:4] = 4'h2; chk_mask("R7");
  endtask

  task automatic t_mclr;
    wr_all_en = 1; wr_all_grp = 0; wr_all_data = 8'h00; step;
    mdl[3:0] = 0;
    mclr = 2'b10; wr_all_en = 1; wr_all_grp = 1; wr_all_data = 8'h00; step;
    mdl[7:4] = 4'hF; chk_mask("R8");
  endtask

  task automatic t_gate;
    wr_all_en = 1; wr_all_grp = 1; wr_all_data = 8'h0C; step;
    mdl[7:4] = 4'hC;
    wr_all_en = 1; wr_all_grp = 0; wr_all_data = 8'h03; step;
    mdl[3:0] = 4'h3;
    dreq_raw = 8'hFF;
    @(posedge clk); @(negedge clk);
    chk("R9", dreq_out, 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R9", dreq_out, ~mdl);
    dreq_raw = 8'h00;
    @(posedge clk); @(negedge clk);
    chk("R9", dreq_out, ~mdl);
    @(posedge clk); @(negedge clk);
    chk("R9", dreq_out, 8'h00);
  endtask

  task automatic t_cascade;
    wr_all_en = 1; wr_all_grp = 1; wr_all_data = 8'h01; step;
    mdl[7:4] = 4'h1;
    wr_all_en = 1; wr_all_grp = 0; wr_all_data = 8'h00; step;
    mdl[3:0] = 4'h0;
    dreq_raw = 8'hFF;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R10", dreq_out, 8'hE0);
    wr_one_en = 1; wr_one_grp = 1; wr_one_data = 3'b000; step;
    chk("R10", dreq_out, 8'hFF);
    dreq_raw = 0;
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
      begin
        @(negedge clk); t_reset;
        @(negedge clk); rst_n = 1;
        @(negedge clk); t_reset;
        t_write_all; t_single; t_single_vs_all; t_tc; t_tc_vs_write;
        t_mclr; t_gate; t_cascade;
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule